// File: doc/BRIEF.md
# E1 CRC-4 Error Supervisor and Remote Alarm Controller

This block watches the CRC-4 error strobes of an E1 receiver and acts on them in two ways. First, it counts CRC errors over a one-second window built from submultiframe ticks. When the count goes above a limit inside that window, it raises a one-cycle request to search again for basic framing and multiframing. Second, it drives the remote alarm bit placed in the transmit stream from the receiver's framing state. An optional extension also raises that bit when multiframe synchronisation has been missing for a timeout period.

The receiver supplies three framing signals: a frame-alignment-lost level, a multiframe-synchronous level and a strobe marking the moment multiframe synchronisation is found. The receiver also supplies one error strobe for each failed submultiframe check and a tick for each submultiframe interval (1 ms). Configuration inputs choose between automatic control and software control of each action.

Top module: `e1_crc_supervisor`

## Requirements
- R1: After reset, `resync_req` is 0, the error count and the timeout count are zero, and `tx_ra` follows R6 to R9 with the timeout treated as not yet elapsed.
- R2: A cycle with `crc_err` high adds one to the error count only while `mf_sync` is 1. Errors seen while `mf_sync` is 0 are discarded.
- R3: A cycle with `mf_found` high sets the error count to zero. A CRC error in that same cycle is discarded.
- R4: Every WINDOW_TICKS `smf_tick` strobes mark the end of a window. On the closing tick the count restarts, and a qualified error in that same cycle counts as the first error of the new window.
- R5: When `auto_lom_en` is 1, `resync_req` is high for exactly one cycle. That cycle is the one after the qualified error that takes the count from ERR_LIMIT to ERR_LIMIT+1. The count then saturates, so at most one request is made per window. When `auto_lom_en` is 0, no request is made.
- R6: When `auto_ra_en` is 1 and `fa_lost` is 1, `tx_ra` is 1.
- R7: When `auto_ra_en` is 1, `fa_lost` is 0 and `mf_sync` is 1, `tx_ra` is 0.
- R8: When `auto_ra_en` is 1 and `fa_lost` is 0, `tx_ra` is 1 if `ext_timeout_en` is 1 and TIMEOUT_TICKS `smf_tick` strobes have been counted while `mf_sync` is 0. Otherwise `tx_ra` is 0. The timeout count is cleared in every cycle in which `mf_sync` is 1.
- R9: When `auto_ra_en` is 0, `tx_ra` equals `sw_ra` whatever the framing inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smf_tick | input | 1 | One-cycle strobe for each submultiframe interval |
| crc_err | input | 1 | One-cycle strobe for a failed submultiframe CRC |
| mf_found | input | 1 | One-cycle strobe when multiframe synchronisation is found |
| mf_sync | input | 1 | Receiver is in the multiframe synchronous state |
| fa_lost | input | 1 | Receiver has lost basic frame alignment |
| auto_lom_en | input | 1 | Enables the automatic resynchronisation request |
| auto_ra_en | input | 1 | Enables automatic remote alarm control |
| ext_timeout_en | input | 1 | Enables the multiframe-loss timeout extension |
| sw_ra | input | 1 | Remote alarm value used when automatic control is off |
| resync_req | output | 1 | One-cycle request to restart the framing search |
| tx_ra | output | 1 | Remote alarm bit for the transmit stream |

## Verification
A wrong error count shows up at `resync_req`. The pulse comes one error too early or too late, comes twice in a window, or is missing after a sync-found event or a window restart. The bench detects any of these in the cycle after the error that should or should not have crossed the limit. A wrong timeout count or window position shows up as `tx_ra` changing on the wrong tick, or a pulse landing in the wrong window. The bench compares both outputs against an arithmetic model on every cycle it drives, so a fault is reported in the first cycle it becomes visible.

// File: rtl/e1_crc_supervisor.sv
module e1_crc_supervisor #(
  parameter int ERR_LIMIT     = 914,
  parameter int WINDOW_TICKS  = 1000,
  parameter int TIMEOUT_TICKS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smf_tick,
  input  logic crc_err,
  input  logic mf_found,
  input  logic mf_sync,
  input  logic fa_lost,
  input  logic auto_lom_en,
  input  logic auto_ra_en,
  input  logic ext_timeout_en,
  input  logic sw_ra,
  output logic resync_req,
  output logic tx_ra
);
  localparam int CNT_MAX = ERR_LIMIT + 1;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int WW = $clog2(WINDOW_TICKS);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);

  logic [CW-1:0] err_cnt;
  logic [WW-1:0] win_pos;
  logic [TW-1:0] to_cnt;

  wire win_end  = smf_tick && (win_pos == WW'(WINDOW_TICKS - 1));
  wire err_hit  = crc_err && mf_sync;
  wire to_done  = (to_cnt == TW'(TIMEOUT_TICKS));
  wire crossing = err_hit && !mf_found && !win_end && (err_cnt == CW'(ERR_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n)        win_pos <= '0;
    else if (smf_tick) win_pos <= win_end ? '0 : win_pos + WW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        err_cnt <= '0;
    else if (mf_found) err_cnt <= '0;
    else if (win_end)  err_cnt <= CW'(err_hit);
    else if (err_hit && err_cnt != CW'(CNT_MAX))
                       err_cnt <= err_cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) resync_req <= 1'b0;
    else        resync_req <= auto_lom_en && crossing;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mf_sync)       to_cnt <= '0;
    else if (smf_tick && !to_done) to_cnt <= to_cnt + TW'(1);
  end

  assign tx_ra = auto_ra_en ? (fa_lost | (!mf_sync & ext_timeout_en & to_done)) : sw_ra;
endmodule

// File: rtl/e1_crc_supervisor_chk.sv
module e1_crc_supervisor_chk #(
  parameter int CNT_MAX = 915,
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          crc_err,
  input logic          mf_found,
  input logic          mf_sync,
  input logic          fa_lost,
  input logic          auto_lom_en,
  input logic          auto_ra_en,
  input logic          sw_ra,
  input logic          resync_req,
  input logic          tx_ra,
  input logic [CW-1:0] err_cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) int'(err_cnt) <= CNT_MAX); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) resync_req |=> !resync_req); // R5
  AST_PULSE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) !auto_lom_en |=> !resync_req); // R5
  AST_NOSYNC_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n) !mf_sync |=> !resync_req); // R2
  AST_FOUND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) mf_found |=> err_cnt == '0); // R3
  AST_RA_ON_FA_LOST: assert property (@(posedge clk) disable iff (!rst_n) (auto_ra_en && fa_lost) |-> tx_ra); // R6
  AST_RA_OFF_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n) (auto_ra_en && !fa_lost && mf_sync) |-> !tx_ra); // R7
  AST_RA_SOFTWARE: assert property (@(posedge clk) disable iff (!rst_n) !auto_ra_en |-> tx_ra == sw_ra); // R9
endmodule

bind e1_crc_supervisor e1_crc_supervisor_chk #(.CNT_MAX(CNT_MAX), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .crc_err(crc_err), .mf_found(mf_found), .mf_sync(mf_sync),
  .fa_lost(fa_lost), .auto_lom_en(auto_lom_en), .auto_ra_en(auto_ra_en), .sw_ra(sw_ra),
  .resync_req(resync_req), .tx_ra(tx_ra), .err_cnt(err_cnt)
);

// File: tb/e1_crc_supervisor_test.sv
module e1_crc_supervisor_test;
  localparam int LIM = 5;
  localparam int WIN = 10;
  localparam int TMO = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smf_tick = 1'b0, crc_err = 1'b0, mf_found = 1'b0, mf_sync = 1'b0, fa_lost = 1'b0;
  logic auto_lom_en = 1'b1, auto_ra_en = 1'b1, ext_timeout_en = 1'b0, sw_ra = 1'b0;
  logic resync_req, tx_ra;

  int checks = 0;
  int fails = 0;
  int m_cnt = 0, m_win = 0, m_to = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  e1_crc_supervisor #(.ERR_LIMIT(LIM), .WINDOW_TICKS(WIN), .TIMEOUT_TICKS(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .smf_tick(smf_tick), .crc_err(crc_err), .mf_found(mf_found),
    .mf_sync(mf_sync), .fa_lost(fa_lost), .auto_lom_en(auto_lom_en), .auto_ra_en(auto_ra_en),
    .ext_timeout_en(ext_timeout_en), .sw_ra(sw_ra), .resync_req(resync_req), .tx_ra(tx_ra)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_ra();
    if (!auto_ra_en) return sw_ra;
    return fa_lost | (!mf_sync & ext_timeout_en & (m_to == TMO));
  endfunction

  task automatic step(input string tag, input logic err, input logic tick, input logic found);
    bit restart, inc;
    logic exp_pulse;
    crc_err = err; smf_tick = tick; mf_found = found;
    restart = tick && (m_win == WIN - 1);
    inc = err && mf_sync;
    exp_pulse = auto_lom_en && inc && !found && !restart && (m_cnt == LIM);
    if (tick) m_win = restart ? 0 : m_win + 1;
    if (found) m_cnt = 0;
    else if (restart) m_cnt = inc ? 1 : 0;
    else if (inc && m_cnt < LIM + 1) m_cnt++;
    if (mf_sync) m_to = 0;
    else if (tick && m_to < TMO) m_to++;
    @(negedge clk);
    check(tag, resync_req, exp_pulse);
    check(tag, tx_ra, exp_ra());
    crc_err = 1'b0; smf_tick = 1'b0; mf_found = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", resync_req, 1'b0);
    check("R1", tx_ra, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 threshold sweep and saturation
    mf_sync = 1'b1;
    for (int k = 0; k < 14; k++) step("R5", 1'b1, 1'b0, 1'b0);

    // R2 errors outside multiframe sync are not counted
    step("R3", 1'b0, 1'b0, 1'b1);
    mf_sync = 1'b0;
    for (int k = 0; k < 10; k++) step("R2", 1'b1, 1'b0, 1'b0);
    mf_sync = 1'b1;
    for (int k = 0; k < 7; k++) step("R2", 1'b1, 1'b0, 1'b0);

    // R3 sync-found clears, error in the same cycle discarded
    step("R3", 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 5; k++) step("R3", 1'b1, 1'b0, 1'b0);
    step("R3", 1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 7; k++) step("R3", 1'b1, 1'b0, 1'b0);

    // R4 window restarts over several tick/error phasings
    for (int p = 0; p < 8; p++) begin
      step("R4", 1'b0, 1'b0, 1'b1);
      for (int i = 0; i < 48; i++)
        step("R4", logic'(((i + p) % 5) != 0), logic'(((i * 3 + p) % 4) == 0), 1'b0);
    end

    // R5 request suppressed when disabled
    auto_lom_en = 1'b0;
    step("R5", 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 9; k++) step("R5", 1'b1, 1'b0, 1'b0);
    auto_lom_en = 1'b1;

    // R6 / R7 automatic remote alarm
    fa_lost = 1'b1; step("R6", 1'b0, 1'b0, 1'b0);
    mf_sync = 1'b0; step("R6", 1'b0, 1'b1, 1'b0);
    fa_lost = 1'b0; mf_sync = 1'b1; step("R7", 1'b0, 1'b0, 1'b0);

    // R8 timeout: without extension stays low, with extension rises after TMO ticks
    mf_sync = 1'b0;
    for (int k = 0; k < 8; k++) step("R8", 1'b0, 1'b1, 1'b0);
    ext_timeout_en = 1'b1; step("R8", 1'b0, 1'b0, 1'b0);
    mf_sync = 1'b1; step("R8", 1'b0, 1'b0, 1'b0);
    mf_sync = 1'b0;
    for (int k = 0; k < 7; k++) begin
      step("R8", 1'b0, 1'b1, 1'b0);
      step("R8", 1'b0, 1'b0, 1'b0);
    end
    mf_sync = 1'b1; step("R8", 1'b0, 1'b1, 1'b0);
    mf_sync = 1'b0;
    for (int k = 0; k < 3; k++) step("R8", 1'b0, 1'b1, 1'b0);

    // R9 software-controlled alarm over all framing combinations
    auto_ra_en = 1'b0;
    for (int c = 0; c < 8; c++) begin
      sw_ra = c[0]; fa_lost = c[1]; mf_sync = c[2];
      step("R9", 1'b0, 1'b1, 1'b0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule